// File: doc/BRIEF.md
# UART Auxiliary Control and Sleep Unit

This block sits next to a UART core and holds one byte of mode bits that software writes over a simple register bus. From those bits it produces four things. It runs a software reset that clears itself. It decides when the UART may enter or leave a low-power sleep state, looking at the receive line either as a level or as a source of transitions. It routes hardware flow control onto one of two modem handshake pairs. It raises the transmit-empty interrupt, which can optionally be held back until the shift register has finished sending.

The FIFOs, shift registers and baud logic belong to the core. They reach this block only as status inputs: the transmit FIFO level, its trigger level, a shift-register-idle flag, a FIFOs-empty flag and a pending-interrupt flag. The receive line passes through a two-flop synchronizer before any sleep decision uses it.

Top module: `uart_aux_unit`

## Requirements
- R1: The control byte reads back on `rdData` with bit 0 = transmit-interrupt mode, bit 1 = software reset busy, bit 2 = flow-pair select and bit 4 = receive-sensitivity mode. Bits 7:5 and 3 always read 0, and writing ones to them has no effect.
- R2: While `rstN` is low, every register bit, `swResetOut`, `sleepMode`, `wakePulse` and `txEmptyIrq` are 0.
- R3: With bit 4 = 0 (level view), sleep is never entered while the synchronized receive line is low. A sleeping unit leaves sleep on the edge after the synchronized line is seen low. The synchronized line lags `rxIn` by two clock edges.
- R4: With bit 4 = 1 (edge view), sleep may be entered with the receive line low. A sleeping unit leaves sleep only when the synchronized line differs from its value one cycle earlier.
- R5: Sleep is entered only when `sleepEn` = 1, `intPending` = 0 and `fifosEmpty` = 1, in addition to the receive-line rule. A sleeping unit also leaves sleep when any of these three conditions stops holding.
- R6: `wakePulse` is high for exactly the one cycle in which `sleepMode` has just fallen, and at no other time.
- R7: With bit 2 = 0, `rtsOut` = `flowReady`, `dtrOut` = `dtrGp` and `flowClear` = `ctsIn`. With bit 2 = 1, `dtrOut` = `flowReady`, `rtsOut` = `rtsGp` and `flowClear` = `dsrIn`.
- R8: Writing 1 to bit 1 while no software reset is running drives `swResetOut` high for exactly 4 cycles, starting the cycle after the write. Bit 1 reads 1 for those cycles and 0 afterwards. The other register bits keep their values. A bit-1 write during a running reset neither restarts nor extends it.
- R9: With bit 0 = 0, `txEmptyIrq` is, one cycle later, 1 exactly when the transmit level is 0 or when it is nonzero and strictly below the trigger level.
- R10: With bit 0 = 1, `txEmptyIrq` is, one cycle later, 1 exactly when the level is nonzero and below the trigger, or when the level is 0 and `tsrIdle` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| rxIn | input | 1 | Raw receive line |
| sleepEn | input | 1 | Sleep permitted by software |
| intPending | input | 1 | Some UART interrupt is pending |
| fifosEmpty | input | 1 | Transmit and receive FIFOs are empty |
| txLevel | input | LEVEL_W | Transmit FIFO fill level |
| txTrigger | input | LEVEL_W | Transmit trigger level |
| tsrIdle | input | 1 | Shift register has sent its last stop bit |
| flowReady | input | 1 | Core ready-to-receive for flow control |
| rtsGp | input | 1 | General-purpose RTS value |
| dtrGp | input | 1 | General-purpose DTR value |
| ctsIn | input | 1 | CTS modem input |
| dsrIn | input | 1 | DSR modem input |
| rtsOut | output | 1 | RTS modem output |
| dtrOut | output | 1 | DTR modem output |
| flowClear | output | 1 | Selected clear-to-send for the transmitter |
| swResetOut | output | 1 | Software reset to the UART core |
| sleepMode | output | 1 | UART is asleep |
| wakePulse | output | 1 | One-cycle wake event |
| txEmptyIrq | output | 1 | Transmit-empty interrupt |

## Verification
The bench drives the receive line low before and during sleep in both views. A design that ignores the synchronizer delay or mixes up the two views would sleep against a low line, or would stay asleep past a transition. It holds the FIFO empty while the shift register is still busy in the deferred interrupt mode, where a design without the idle gate raises the interrupt early. It also writes the reset bit again during a running reset and sets every reserved bit, which exposes a stretched reset, a restarted reset or a reserved bit that reads back.

// File: rtl/uart_aux_pkg.sv
package uart_aux_pkg;
  localparam int POS_TSR_MODE = 0;
  localparam int POS_SW_RESET = 1;
  localparam int POS_FLOW_SEL = 2;
  localparam int POS_RX_EDGE  = 4;
  localparam logic [7:0] WR_MASK = 8'b0001_0101;

  typedef struct packed {
    logic regLoad;
    logic rstBusy;
  } auxStrobe_t;

  typedef enum logic {
    PWR_AWAKE  = 1'b0,
    PWR_ASLEEP = 1'b1
  } pwrState_t;
endpackage

// File: rtl/uart_aux_datapath.sv
module uart_aux_datapath
  import uart_aux_pkg::*;
#(
  parameter int LEVEL_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  auxStrobe_t         strb,
  input  logic [7:0]         wrData,
  input  logic               rxIn,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] txTrigger,
  input  logic               tsrIdle,
  input  logic               flowReady,
  input  logic               rtsGp,
  input  logic               dtrGp,
  input  logic               ctsIn,
  input  logic               dsrIn,
  output logic [7:0]         rdData,
  output logic               rxEdgeMode,
  output logic               rxSync,
  output logic               rxEdge,
  output logic               txEmptyIrq,
  output logic               rtsOut,
  output logic               dtrOut,
  output logic               flowClear
);
  logic [7:0] ctrlBits;
  logic [SYNC_STAGES-1:0] syncChain;
  logic rxPrev;
  logic tsrMode, flowDtr;
  logic belowTrig, fifoDrained, irqNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlBits <= '0;
    else if (strb.regLoad) ctrlBits <= wrData & WR_MASK;
  end

  assign tsrMode    = ctrlBits[POS_TSR_MODE];
  assign flowDtr    = ctrlBits[POS_FLOW_SEL];
  assign rxEdgeMode = ctrlBits[POS_RX_EDGE];

  always_comb begin
    rdData = ctrlBits;
    rdData[POS_SW_RESET] = strb.rstBusy;
  end

  // receive synchronizer, idle-high line
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b1;
          else       syncChain[0] <= rxIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= 1'b1;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  assign rxSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxPrev <= 1'b1;
    else       rxPrev <= rxSync;
  end

  assign rxEdge = rxSync ^ rxPrev;

  // transmit-empty interrupt
  always_comb begin
    fifoDrained = (txLevel == '0);
    belowTrig   = !fifoDrained && (txLevel < txTrigger);
    irqNext     = belowTrig || (fifoDrained && (!tsrMode || tsrIdle));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txEmptyIrq <= 1'b0;
    else       txEmptyIrq <= irqNext;
  end

  // flow-control pair routing
  always_comb begin
    if (flowDtr) begin
      dtrOut    = flowReady;
      rtsOut    = rtsGp;
      flowClear = dsrIn;
    end else begin
      rtsOut    = flowReady;
      dtrOut    = dtrGp;
      flowClear = ctsIn;
    end
  end

  AST_IRQ_HELD_TSR: assert property (@(posedge clk) disable iff (!rstN)
    $past(tsrMode && (txLevel == '0) && !tsrIdle) |-> !txEmptyIrq); // R10
  AST_IRQ_BELOW_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    $past((txLevel != '0) && (txLevel < txTrigger)) |-> txEmptyIrq); // R9
  AST_IRQ_ABOVE_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    $past((txLevel != '0) && (txLevel >= txTrigger)) |-> !txEmptyIrq); // R9
endmodule

// File: rtl/uart_aux_control.sv
module uart_aux_control
  import uart_aux_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSwRst,
  input  logic       rxEdgeMode,
  input  logic       rxSync,
  input  logic       rxEdge,
  input  logic       sleepEn,
  input  logic       intPending,
  input  logic       fifosEmpty,
  output auxStrobe_t strb,
  output logic       swResetOut,
  output logic       sleepMode,
  output logic       wakePulse
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] rstCnt;
  pwrState_t pwrState, pwrNext;
  logic rxWake, enterOk, leaveReq;

  // software reset sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               rstCnt <= '0;
    else if (wrEn && wrSwRst && rstCnt == '0) rstCnt <= CNT_W'(RST_CYCLES);
    else if (rstCnt != '0)                    rstCnt <= rstCnt - 1'b1;
  end

  assign swResetOut   = (rstCnt != '0);
  assign strb.regLoad = wrEn;
  assign strb.rstBusy = swResetOut;

  // sleep arbiter
  always_comb begin
    rxWake   = rxEdgeMode ? rxEdge : !rxSync;
    enterOk  = sleepEn && !intPending && fifosEmpty && (rxEdgeMode || rxSync);
    leaveReq = !sleepEn || intPending || !fifosEmpty || rxWake;
    pwrNext  = pwrState;
    case (pwrState)
      PWR_AWAKE:  if (enterOk)  pwrNext = PWR_ASLEEP;
      PWR_ASLEEP: if (leaveReq) pwrNext = PWR_AWAKE;
      default:    pwrNext = PWR_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrState  <= PWR_AWAKE;
      wakePulse <= 1'b0;
    end else begin
      pwrState  <= pwrNext;
      wakePulse <= (pwrState == PWR_ASLEEP) && leaveReq;
    end
  end

  assign sleepMode = (pwrState == PWR_ASLEEP);

  logic [CNT_W:0] busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           busyLen <= '0;
    else if (swResetOut) busyLen <= busyLen + 1'b1;
    else                 busyLen <= '0;
  end

  AST_RST_NOT_LONG: assert property (@(posedge clk) disable iff (!rstN)
    swResetOut |-> (int'(busyLen) < RST_CYCLES)); // R8
  AST_RST_FULL_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(swResetOut) |-> (int'(busyLen) == RST_CYCLES)); // R8
  AST_NO_SLEEP_RX_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepMode && !rxEdgeMode && !rxSync) |=> !sleepMode); // R3
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (sleepMode && rxEdgeMode && !rxEdge && sleepEn && !intPending && fifosEmpty)
      |=> sleepMode); // R4
  AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepMode && (!sleepEn || intPending || !fifosEmpty)) |=> !sleepMode); // R5
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse); // R6
  AST_WAKE_AFTER_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (!sleepMode && $past(sleepMode))); // R6
endmodule

// File: rtl/uart_aux_unit.sv
module uart_aux_unit
  import uart_aux_pkg::*;
#(
  parameter int LEVEL_W     = 8,
  parameter int RST_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [7:0]         wrData,
  output logic [7:0]         rdData,
  input  logic               rxIn,
  input  logic               sleepEn,
  input  logic               intPending,
  input  logic               fifosEmpty,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] txTrigger,
  input  logic               tsrIdle,
  input  logic               flowReady,
  input  logic               rtsGp,
  input  logic               dtrGp,
  input  logic               ctsIn,
  input  logic               dsrIn,
  output logic               rtsOut,
  output logic               dtrOut,
  output logic               flowClear,
  output logic               swResetOut,
  output logic               sleepMode,
  output logic               wakePulse,
  output logic               txEmptyIrq
);
  auxStrobe_t strb;
  logic rxEdgeMode, rxSync, rxEdge;

  uart_aux_control #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSwRst(wrData[POS_SW_RESET]),
    .rxEdgeMode(rxEdgeMode), .rxSync(rxSync), .rxEdge(rxEdge),
    .sleepEn(sleepEn), .intPending(intPending), .fifosEmpty(fifosEmpty),
    .strb(strb), .swResetOut(swResetOut), .sleepMode(sleepMode),
    .wakePulse(wakePulse)
  );

  uart_aux_datapath #(.LEVEL_W(LEVEL_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rxIn(rxIn),
    .txLevel(txLevel), .txTrigger(txTrigger), .tsrIdle(tsrIdle),
    .flowReady(flowReady), .rtsGp(rtsGp), .dtrGp(dtrGp), .ctsIn(ctsIn),
    .dsrIn(dsrIn), .rdData(rdData), .rxEdgeMode(rxEdgeMode),
    .rxSync(rxSync), .rxEdge(rxEdge), .txEmptyIrq(txEmptyIrq),
    .rtsOut(rtsOut), .dtrOut(dtrOut), .flowClear(flowClear)
  );
endmodule

// File: tb/uart_aux_unit_test.sv
module uart_aux_unit_test;
  localparam int LW = 8;
  localparam int RSTC = 4;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic rxIn = 1, sleepEn = 0, intPending = 0, fifosEmpty = 1;
  logic [LW-1:0] txLevel = 0, txTrigger = 0;
  logic tsrIdle = 0, flowReady = 0, rtsGp = 0, dtrGp = 0, ctsIn = 0, dsrIn = 0;
  logic rtsOut, dtrOut, flowClear, swResetOut, sleepMode, wakePulse, txEmptyIrq;

  always #2 clk = ~clk;

  uart_aux_unit #(.LEVEL_W(LW), .RST_CYCLES(RSTC), .SYNC_STAGES(2)) uut (.*);

  int vectors = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  int mB4, mB2, mB0, mCnt, mS1, mS2, mPrev, mAsleep, mWake, mIrq;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mB4 = 0; mB2 = 0; mB0 = 0; mCnt = 0;
      mS1 = 1; mS2 = 1; mPrev = 1; mAsleep = 0; mWake = 0; mIrq = 0;
    end else begin
      int edgeSeen, rxW, goSleep, leave, lvl, trg;
      edgeSeen = (mS2 != mPrev);
      rxW   = mB4 ? edgeSeen : (mS2 == 0);
      goSleep = sleepEn && !intPending && fifosEmpty && (mB4 || mS2 == 1);
      leave = !sleepEn || intPending || !fifosEmpty || rxW;
      lvl = txLevel; trg = txTrigger;
      mIrq = (lvl != 0 && lvl < trg) || (lvl == 0 && (mB0 == 0 || tsrIdle));
      mWake = mAsleep && leave;
      if (mAsleep) mAsleep = !leave; else mAsleep = goSleep;
      if (wrEn && wrData[1] && mCnt == 0) mCnt = RSTC;
      else if (mCnt > 0) mCnt--;
      if (wrEn) begin mB4 = wrData[4]; mB2 = wrData[2]; mB0 = wrData[0]; end
      mPrev = mS2; mS2 = mS1; mS1 = rxIn;
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN && !done) begin
    int expRd;
    expRd = (mB4 << 4) | (mB2 << 2) | ((mCnt != 0) << 1) | mB0;
    chk("R1/R8 rdData", rdData, expRd);
    chk("R8 swResetOut", swResetOut, mCnt != 0);
    chk("R3/R4/R5 sleepMode", sleepMode, mAsleep);
    chk("R6 wakePulse", wakePulse, mWake);
    chk(mB0 ? "R10 txEmptyIrq" : "R9 txEmptyIrq", txEmptyIrq, mIrq);
    chk("R7 rtsOut", rtsOut, mB2 ? rtsGp : flowReady);
    chk("R7 dtrOut", dtrOut, mB2 ? flowReady : dtrGp);
    chk("R7 flowClear", flowClear, mB2 ? dsrIn : ctsIn);
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); #1; wrEn = 1; wrData = v;
    @(negedge clk); #1; wrEn = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    txTrigger = 4; txLevel = 8;
    tick(3);
    // R2: hold reset, outputs idle
    chk("R2 rdData", rdData, 0);
    chk("R2 swResetOut", swResetOut, 0);
    chk("R2 sleepMode", sleepMode, 0);
    chk("R2 wakePulse", wakePulse, 0);
    chk("R2 txEmptyIrq", txEmptyIrq, 0);
    rstN = 1;
    tick(2);

    // R1 reserved bits, R8 reset pulse, re-write during reset
    wr(8'hFF);
    tick(1);
    wr(8'h02);
    tick(6);
    wr(8'h17);
    tick(8);

    // R7 flow routing in both selections
    for (int sel = 0; sel < 2; sel++) begin
      wr(sel ? 8'h04 : 8'h00);
      for (int p = 0; p < 32; p++) begin
        {flowReady, rtsGp, dtrGp, ctsIn, dsrIn} = 5'(p);
        tick(1);
      end
    end

    // R9/R10 interrupt modes
    wr(8'h01);
    txLevel = 0; tsrIdle = 0; tick(3);
    tsrIdle = 1; tick(3);
    txLevel = 3; tsrIdle = 0; tick(2);
    txLevel = 4; tick(2);
    txLevel = 6; tick(2);
    txTrigger = 0; txLevel = 0; tick(2);
    wr(8'h00);
    txTrigger = 4; tsrIdle = 0; tick(3);
    txLevel = 9; tick(2);

    // R3/R5 level view
    rxIn = 1; sleepEn = 1; fifosEmpty = 1; tick(4);
    rxIn = 0; tick(5);
    tick(5);
    rxIn = 1; tick(5);
    intPending = 1; tick(3);
    intPending = 0; tick(3);
    fifosEmpty = 0; tick(3);
    fifosEmpty = 1; tick(3);
    sleepEn = 0; tick(3);
    sleepEn = 1; rxIn = 0; tick(1); rxIn = 1; tick(6);

    // R4 edge view
    wr(8'h10);
    rxIn = 0; tick(10);
    rxIn = 1; tick(6);
    rxIn = 0; tick(6);
    sleepEn = 0; tick(3);

    // R8 software reset keeps other bits
    wr(8'h15); tick(2);
    wr(8'h17); tick(8);

    // mixed stimulus
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #1;
      rxIn       = ($urandom % 5) != 0;
      sleepEn    = ($urandom % 6) != 0;
      intPending = ($urandom % 8) == 0;
      fifosEmpty = ($urandom % 6) != 0;
      txLevel    = LW'($urandom % 6);
      txTrigger  = LW'($urandom % 6);
      tsrIdle    = $urandom % 2;
      {flowReady, rtsGp, dtrGp, ctsIn, dsrIn} = 5'($urandom);
      wrEn       = ($urandom % 12) == 0;
      wrData     = 8'($urandom);
    end
    wrEn = 0;
    tick(6);

    done = 1;
    summary();
    $finish;
  end
endmodule